// File: doc/BRIEF.md
# Column Command Slot Decoder

This block receives the column half of a memory device's control channel: a 5-lane bus that carries one sample on each clock edge, delivered to the block as one 10-bit beat per clock. The early half-cycle sample sits in bits [4:0] and the late one in bits [9:5]. A slot is four clocks (40 bits) long and is found by a start bit. The first 23 bits of a slot are a column-operation packet. The other 17 bits are a companion packet. A mode bit in the companion packet makes it either a pair of write byte masks or an extended operation with its own device and bank fields.

The decoder compares the device fields with the local device number, `dev_id_i`. It turns the 4-bit column opcode and the 5-bit extended opcode into single-cycle command strobes. It also exports the bank, column and mask values that go with those strobes. A power-state input, `attn_i`, decides whether the device is listening. When it is low, a slot is framed but produces no command. The write buffer, the storage array and the current-calibration analog belong to neighbouring blocks.

The framer is a four-state machine:

- `HUNT` waits for the start bit and goes to `GATHER1` on the beat that carries it.
- `GATHER1` goes to `GATHER2`, and `GATHER2` goes to `GATHER3`, unconditionally.
- `GATHER3` always returns to `HUNT`. The decode result is registered on that edge.

Top module: `colpkt_decoder`

## Requirements
- R1: In `HUNT`, a beat whose bit 0 is 1 starts a slot. That beat and the next three beats form the slot. `frame_o` pulses for one cycle, in the cycle after the fourth beat is sampled. Bit 0 of beats two to four never starts a slot. A new slot may begin on the beat that follows the fourth beat.
- R2: Slot bit n is bit (n mod 10) of beat (n div 10). The fields are placed as follows. Start bit is bit 0. Device number is bits [5:1]. Bank is bits [10:6]. Column is bits [16:11]. Opcode is bits [20:17]. Bits [22:21] are ignored. Mode is bit 23. With mode 1, byte mask A is bits [31:24] and byte mask B is bits [39:32]. With mode 0, the extended device number is bits [28:24], the extended bank is bits [33:29], the extended opcode is bits [38:34], and bit 39 is ignored.
- R3: The low three opcode bits decode as follows. 000 gives retire. 001 gives retire and write. 011 gives read. 100 gives retire and precharge. 101 gives retire, write and precharge. 111 gives read and precharge. 010 and 110 give nothing.
- R4: Opcode bit 3 set raises `relax_o`, in addition to whatever the low three bits decode to.
- R5: The column-operation strobes (`rd_o`, `wr_o`, `retire_o`, `pre_o`, and `relax_o` from the opcode) fire only when the slot's device number equals `dev_id_i`. `bank_o` and `col_o` load only on such a slot.
- R6: With mode 1, `mask_vld_o` pulses and `mask_a_o`/`mask_b_o` load the two mask bytes. The mask packet has no device field, so the device-number comparison does not affect it.
- R7: With mode 0 and extended opcode bit 0 clear, the extended opcode decodes as follows. Bit 4 gives precharge of the extended bank (`prex_o`, with `xbank_o` loaded). Bit 3 gives calibrate. Bits 3 and 2 together give calibrate and sample. Bit 1 gives relax. These may combine. Extended opcode bit 0 set makes the whole extended operation a no-op.
- R8: The extended operation acts only when the extended device number equals `dev_id_i`, whatever the column-operation device number is.
- R9: If `attn_i` is low in the cycle the fourth beat is sampled, every strobe other than `frame_o` stays low and no data output loads. `accept_o` equals `attn_i` delayed by one clock.
- R10: After reset every output is 0 and the framer is in `HUNT`.
- R11: `bank_o`, `col_o`, `mask_a_o`, `mask_b_o` and `xbank_o` hold their values until a slot loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_beat_i | input | 10 | Two bus samples per clock, early half in [4:0] |
| dev_id_i | input | 5 | Local device number |
| attn_i | input | 1 | Device is in the state that accepts column commands |
| frame_o | output | 1 | Slot completed |
| accept_o | output | 1 | Registered acceptance gate |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| retire_o | output | 1 | Retire-write-buffer strobe |
| pre_o | output | 1 | Precharge of the column bank |
| relax_o | output | 1 | Relax power transition, from either packet |
| bank_o | output | 5 | Column-operation bank |
| col_o | output | 6 | Column address |
| mask_vld_o | output | 1 | Mask bytes valid |
| mask_a_o | output | 8 | Byte mask A |
| mask_b_o | output | 8 | Byte mask B |
| prex_o | output | 1 | Extended precharge strobe |
| xbank_o | output | 5 | Extended precharge bank |
| cal_o | output | 1 | Calibrate strobe |
| sam_o | output | 1 | Sample strobe |

## Verification
A column-operation command and an extended operation come from the same slot, so they reach the outputs in the same cycle. For example, a read with precharge on one bank can arrive together with an extended precharge on another. Relax can be requested by both packets at once, and it must appear as one pulse.

The bench provokes the overlap by holding a matching read-with-precharge in the column packet while it sweeps all 32 extended opcodes under a matching extended device number. It then repeats the sweep with the column device number mismatched. Each outcome is judged against values worked out from the field bits. Extended strobes must be the same in both sweeps, while the column strobes must disappear in the mismatched one.

// File: rtl/colpkt_pkg.sv
package colpkt_pkg;

    // bus geometry
    parameter int LANE_W   = 5;
    parameter int SLOT_CYC = 4;
    parameter int BEAT_W   = 2 * LANE_W;
    parameter int SLOT_W   = BEAT_W * SLOT_CYC;

    // field widths
    parameter int DEV_W  = 5;
    parameter int BANK_W = 5;
    parameter int COL_W  = 6;
    parameter int COP_W  = 4;
    parameter int XOP_W  = 5;
    parameter int MASK_W = 8;
    parameter int OPPKT_W = 23;

    // field positions inside the assembled slot
    parameter int START_POS = 0;
    parameter int DC_LO     = START_POS + 1;
    parameter int BC_LO     = DC_LO + DEV_W;
    parameter int CA_LO     = BC_LO + BANK_W;
    parameter int COP_LO    = CA_LO + COL_W;
    parameter int MODE_POS  = OPPKT_W;
    parameter int MA_LO     = MODE_POS + 1;
    parameter int MB_LO     = MA_LO + MASK_W;
    parameter int DX_LO     = MODE_POS + 1;
    parameter int BX_LO     = DX_LO + DEV_W;
    parameter int XOP_LO    = BX_LO + BANK_W;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic              hit;
        logic              rd;
        logic              wr;
        logic              retire;
        logic              pre;
        logic              relax;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } op_cmd_t;

    typedef struct packed {
        logic              mask_vld;
        logic [MASK_W-1:0] ma;
        logic [MASK_W-1:0] mb;
        logic              x_hit;
        logic              prex;
        logic              cal;
        logic              sam;
        logic              relax;
        logic [BANK_W-1:0] xbank;
    } side_cmd_t;

    typedef enum logic [1:0] {
        HUNT    = 2'd0,
        GATHER1 = 2'd1,
        GATHER2 = 2'd2,
        GATHER3 = 2'd3
    } frame_st_e;

endpackage

// File: rtl/colpkt_framer.sv
module colpkt_framer
    import colpkt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BEAT_W-1:0] beat_i,
    output slot_t             slot_o,
    output logic              done_o
);

    localparam int HELD_W = SLOT_W - BEAT_W;

    frame_st_e          st_q, st_d;
    logic [HELD_W-1:0]  held_q;
    logic               capture;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= HUNT;
        else         st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HUNT:    st_d = beat_i[START_POS] ? GATHER1 : HUNT;
            GATHER1: st_d = GATHER2;
            GATHER2: st_d = GATHER3;
            GATHER3: st_d = HUNT;
            default: st_d = HUNT;
        endcase
    end

    // earlier beats are held; the last one is used live
    assign capture = (st_q == HUNT) ? beat_i[START_POS] : (st_q != GATHER3);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= '0;
        end else if (capture) begin
            held_q[int'(st_q)*BEAT_W +: BEAT_W] <= beat_i;
        end
    end

    assign slot_o = {beat_i, held_q};
    assign done_o = (st_q == GATHER3);

endmodule

// File: rtl/colpkt_opdec.sv
module colpkt_opdec
    import colpkt_pkg::*;
(
    input  slot_t             slot_i,
    input  logic [DEV_W-1:0]  dev_id_i,
    output op_cmd_t           cmd_o
);

    logic [COP_W-1:0] cop;
    logic             unused_bits;

    assign cop = slot_i[COP_LO +: COP_W];
    assign unused_bits = ^{slot_i[START_POS], slot_i[SLOT_W-1:COP_LO+COP_W]};

    always_comb begin
        cmd_o        = '0;
        cmd_o.hit    = (slot_i[DC_LO +: DEV_W] == dev_id_i);
        cmd_o.bank   = slot_i[BC_LO +: BANK_W];
        cmd_o.col    = slot_i[CA_LO +: COL_W];
        cmd_o.relax  = cop[COP_W-1];
        unique case (cop[2:0])
            3'b000: cmd_o.retire = 1'b1;
            3'b001: begin
                cmd_o.retire = 1'b1;
                cmd_o.wr     = 1'b1;
            end
            3'b011: cmd_o.rd = 1'b1;
            3'b100: begin
                cmd_o.retire = 1'b1;
                cmd_o.pre    = 1'b1;
            end
            3'b101: begin
                cmd_o.retire = 1'b1;
                cmd_o.wr     = 1'b1;
                cmd_o.pre    = 1'b1;
            end
            3'b111: begin
                cmd_o.rd  = 1'b1;
                cmd_o.pre = 1'b1;
            end
            default: ; // reserved codes do nothing
        endcase
    end

endmodule

// File: rtl/colpkt_sidedec.sv
module colpkt_sidedec
    import colpkt_pkg::*;
(
    input  slot_t             slot_i,
    input  logic [DEV_W-1:0]  dev_id_i,
    output side_cmd_t         cmd_o
);

    logic             mode;
    logic [XOP_W-1:0] xop;
    logic             xop_live;
    logic             unused_bits;

    assign mode     = slot_i[MODE_POS];
    assign xop      = slot_i[XOP_LO +: XOP_W];
    assign xop_live = !xop[0];
    assign unused_bits = ^slot_i[MODE_POS-1:0];

    always_comb begin
        cmd_o          = '0;
        cmd_o.ma       = slot_i[MA_LO +: MASK_W];
        cmd_o.mb       = slot_i[MB_LO +: MASK_W];
        cmd_o.xbank    = slot_i[BX_LO +: BANK_W];
        cmd_o.mask_vld = mode;
        cmd_o.x_hit    = !mode && (slot_i[DX_LO +: DEV_W] == dev_id_i);
        if (xop_live) begin
            cmd_o.prex  = xop[4];
            cmd_o.cal   = xop[3];
            cmd_o.sam   = xop[3] && xop[2];
            cmd_o.relax = xop[1];
        end
    end

endmodule

// File: rtl/colpkt_decoder.sv
module colpkt_decoder
    import colpkt_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [BEAT_W-1:0]  col_beat_i,
    input  logic [DEV_W-1:0]   dev_id_i,
    input  logic               attn_i,
    output logic               frame_o,
    output logic               accept_o,
    output logic               rd_o,
    output logic               wr_o,
    output logic               retire_o,
    output logic               pre_o,
    output logic               relax_o,
    output logic [BANK_W-1:0]  bank_o,
    output logic [COL_W-1:0]   col_o,
    output logic               mask_vld_o,
    output logic [MASK_W-1:0]  mask_a_o,
    output logic [MASK_W-1:0]  mask_b_o,
    output logic               prex_o,
    output logic [BANK_W-1:0]  xbank_o,
    output logic               cal_o,
    output logic               sam_o
);

    slot_t     slot;
    logic      slot_done;
    op_cmd_t   op_cmd;
    side_cmd_t side_cmd;
    logic      op_go, x_go, m_go;

    colpkt_framer u_framer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .beat_i (col_beat_i),
        .slot_o (slot),
        .done_o (slot_done)
    );

    colpkt_opdec u_opdec (
        .slot_i   (slot),
        .dev_id_i (dev_id_i),
        .cmd_o    (op_cmd)
    );

    colpkt_sidedec u_sidedec (
        .slot_i   (slot),
        .dev_id_i (dev_id_i),
        .cmd_o    (side_cmd)
    );

    assign op_go = slot_done && attn_i && op_cmd.hit;
    assign x_go  = slot_done && attn_i && side_cmd.x_hit;
    assign m_go  = slot_done && attn_i && side_cmd.mask_vld;

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frame_o    <= 1'b0;
            accept_o   <= 1'b0;
            rd_o       <= 1'b0;
            wr_o       <= 1'b0;
            retire_o   <= 1'b0;
            pre_o      <= 1'b0;
            relax_o    <= 1'b0;
            bank_o     <= '0;
            col_o      <= '0;
            mask_vld_o <= 1'b0;
            mask_a_o   <= '0;
            mask_b_o   <= '0;
            prex_o     <= 1'b0;
            xbank_o    <= '0;
            cal_o      <= 1'b0;
            sam_o      <= 1'b0;
        end else begin
            frame_o    <= slot_done;
            accept_o   <= attn_i;
            rd_o       <= op_go && op_cmd.rd;
            wr_o       <= op_go && op_cmd.wr;
            retire_o   <= op_go && op_cmd.retire;
            pre_o      <= op_go && op_cmd.pre;
            relax_o    <= (op_go && op_cmd.relax) || (x_go && side_cmd.relax);
            mask_vld_o <= m_go;
            prex_o     <= x_go && side_cmd.prex;
            cal_o      <= x_go && side_cmd.cal;
            sam_o      <= x_go && side_cmd.sam;
            if (op_go) begin
                bank_o <= op_cmd.bank;
                col_o  <= op_cmd.col;
            end
            if (m_go) begin
                mask_a_o <= side_cmd.ma;
                mask_b_o <= side_cmd.mb;
            end
            if (x_go && side_cmd.prex) begin
                xbank_o <= side_cmd.xbank;
            end
        end
    end

endmodule

// File: rtl/colpkt_decoder_chk.sv
module colpkt_decoder_chk
    import colpkt_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              attn_i,
    input logic              frame_o,
    input logic              accept_o,
    input logic              rd_o,
    input logic              wr_o,
    input logic              retire_o,
    input logic              pre_o,
    input logic              relax_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              mask_vld_o,
    input logic              prex_o,
    input logic              cal_o,
    input logic              sam_o
);

    // R1
    frame_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> (!$past(frame_o) && !$past(frame_o, 2) && !$past(frame_o, 3)));

    // R1
    strobe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_o || wr_o || retire_o || pre_o || relax_o || mask_vld_o || prex_o || cal_o || sam_o)
        |-> frame_o);

    // R3
    read_no_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_o |-> (!retire_o && !wr_o));

    // R7
    sample_needs_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sam_o |-> cal_o);

    // R9
    gate_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_o && !accept_o) |-> !(rd_o || wr_o || retire_o || pre_o || relax_o ||
                                     mask_vld_o || prex_o || cal_o || sam_o));

    // R9
    accept_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (accept_o == $past(attn_i)));

    // R11
    bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_o |-> $stable(bank_o));

endmodule

bind colpkt_decoder colpkt_decoder_chk chk_i (.*);

// File: tb/colpkt_decoder_tb.sv
`timescale 1ns/1ps
module colpkt_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] beat = '0;
    logic [4:0] dev = 5'h0B;
    logic       attn = 1'b0;

    logic       frame_o, accept_o, rd_o, wr_o, retire_o, pre_o, relax_o;
    logic [4:0] bank_o, xbank_o;
    logic [5:0] col_o;
    logic       mask_vld_o, prex_o, cal_o, sam_o;
    logic [7:0] mask_a_o, mask_b_o;

    int tests = 0;
    int fails = 0;

    // model of held data outputs
    logic [4:0] m_bank = '0, m_xbank = '0;
    logic [5:0] m_col = '0;
    logic [7:0] m_ma = '0, m_mb = '0;

    always #2 clk = ~clk;

    colpkt_decoder dut_i (
        .clk_i(clk), .rst_ni(rst_n), .col_beat_i(beat), .dev_id_i(dev), .attn_i(attn),
        .frame_o(frame_o), .accept_o(accept_o), .rd_o(rd_o), .wr_o(wr_o),
        .retire_o(retire_o), .pre_o(pre_o), .relax_o(relax_o), .bank_o(bank_o),
        .col_o(col_o), .mask_vld_o(mask_vld_o), .mask_a_o(mask_a_o), .mask_b_o(mask_b_o),
        .prex_o(prex_o), .xbank_o(xbank_o), .cal_o(cal_o), .sam_o(sam_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R2 layout, written with literal bit positions
    function automatic logic [39:0] mk(input logic [4:0] dc, input logic [4:0] bc,
                                       input logic [5:0] c, input logic [3:0] cop,
                                       input logic m, input logic [7:0] a,
                                       input logic [7:0] b, input logic [4:0] dx,
                                       input logic [4:0] bx, input logic [4:0] xop,
                                       input logic [2:0] rsv);
        logic [39:0] v;
        v = '0;
        v[0] = 1'b1;
        v[5:1] = dc; v[10:6] = bc; v[16:11] = c; v[20:17] = cop;
        v[22:21] = rsv[1:0];
        v[23] = m;
        if (m) begin
            v[31:24] = a; v[39:32] = b;
        end else begin
            v[28:24] = dx; v[33:29] = bx; v[38:34] = xop; v[39] = rsv[2];
        end
        return v;
    endfunction

    task automatic judge(input logic [39:0] v);
        logic [2:0] c;
        logic [4:0] xop;
        logic hit, xh, mv;
        logic e_rd, e_wr, e_ret, e_pre, e_rlx, e_prex, e_cal, e_sam;
        c = v[19:17];
        xop = v[38:34];
        hit = attn && (v[5:1] == dev);
        xh  = attn && !v[23] && (v[28:24] == dev) && !xop[0];
        mv  = attn && v[23];
        e_rd  = hit && (c == 3'd3 || c == 3'd7);
        e_wr  = hit && (c == 3'd1 || c == 3'd5);
        e_ret = hit && (c == 3'd0 || c == 3'd1 || c == 3'd4 || c == 3'd5);
        e_pre = hit && (c == 3'd4 || c == 3'd5 || c == 3'd7);
        e_rlx = (hit && v[20]) || (xh && xop[1]);
        e_prex = xh && xop[4];
        e_cal  = xh && xop[3];
        e_sam  = xh && xop[3] && xop[2];
        if (hit) begin m_bank = v[10:6]; m_col = v[16:11]; end
        if (mv) begin m_ma = v[31:24]; m_mb = v[39:32]; end
        if (e_prex) m_xbank = v[33:29];
        chk("R1", "frame", int'(frame_o), 1);
        chk("R3", "rd", int'(rd_o), int'(e_rd));
        chk("R3", "wr", int'(wr_o), int'(e_wr));
        chk("R3", "retire", int'(retire_o), int'(e_ret));
        chk("R5", "pre", int'(pre_o), int'(e_pre));
        chk("R4", "relax", int'(relax_o), int'(e_rlx));
        chk("R6", "mask_vld", int'(mask_vld_o), int'(mv));
        chk("R7", "prex", int'(prex_o), int'(e_prex));
        chk("R7", "cal", int'(cal_o), int'(e_cal));
        chk("R8", "sam", int'(sam_o), int'(e_sam));
        chk("R11", "bank", int'(bank_o), int'(m_bank));
        chk("R11", "col", int'(col_o), int'(m_col));
        chk("R6", "mask_a", int'(mask_a_o), int'(m_ma));
        chk("R6", "mask_b", int'(mask_b_o), int'(m_mb));
        chk("R7", "xbank", int'(xbank_o), int'(m_xbank));
    endtask

    task automatic beats_tail(input logic [39:0] v);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk("R1", "no early frame", int'(frame_o), 0);
            beat = v[k*10 +: 10];
        end
    endtask

    task automatic play(input logic [39:0] v);
        @(negedge clk);
        beat = v[9:0];
        beats_tail(v);
        @(negedge clk);
        judge(v);
        beat = '0;
    endtask

    task automatic play2(input logic [39:0] a, input logic [39:0] b);
        @(negedge clk);
        beat = a[9:0];
        beats_tail(a);
        @(negedge clk);
        judge(a);
        beat = b[9:0];
        beats_tail(b);
        @(negedge clk);
        judge(b);
        beat = '0;
    endtask

    function automatic logic [4:0] other(input logic [4:0] d);
        logic [4:0] r;
        r = 5'($urandom_range(1, 31));
        return d ^ r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [39:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10", "frame", int'(frame_o), 0);
        chk("R10", "accept", int'(accept_o), 0);
        chk("R10", "strobes", int'({rd_o, wr_o, retire_o, pre_o, relax_o, mask_vld_o, prex_o, cal_o, sam_o}), 0);
        chk("R10", "data", int'({bank_o, col_o, xbank_o}), 0);
        chk("R10", "masks", int'({mask_a_o, mask_b_o}), 0);

        // R1 idle noise with bit 0 low never frames
        for (int i = 0; i < 8; i++) begin
            beat = 10'($urandom) & 10'h3FE;
            @(negedge clk);
            chk("R1", "idle noise", int'(frame_o), 0);
        end
        beat = '0;

        // R9 acceptance gate follows attn one cycle later
        for (int i = 0; i < 4; i++) begin
            attn = i[0];
            @(negedge clk);
            chk("R9", "accept", int'(accept_o), int'(attn));
        end
        attn = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 opcode sweep with mask companion, matching and not
        for (int cop = 0; cop < 16; cop++) begin
            for (int mt = 0; mt < 2; mt++) begin
                v = mk(mt ? dev : other(dev), 5'($urandom), 6'($urandom), 4'(cop), 1'b1,
                       8'($urandom), 8'($urandom), 5'd0, 5'd0, 5'd0, 3'($urandom));
                play(v);
            end
        end

        // R7 R8 extended sweep, column packet a matching read with precharge
        for (int x = 0; x < 32; x++) begin
            for (int mt = 0; mt < 2; mt++) begin
                v = mk(dev, 5'($urandom), 6'($urandom), 4'b0111, 1'b0, 8'd0, 8'd0,
                       mt ? dev : other(dev), 5'($urandom), 5'(x), 3'($urandom));
                play(v);
            end
        end

        // R8 extended sweep with column device mismatched
        for (int x = 0; x < 32; x++) begin
            v = mk(other(dev), 5'($urandom), 6'($urandom), 5'($urandom) & 4'hF, 1'b0, 8'd0, 8'd0,
                   dev, 5'($urandom), 5'(x), 3'($urandom));
            play(v);
        end

        // R9 gate closed: nothing but frame
        attn = 1'b0;
        for (int cop = 0; cop < 16; cop++) begin
            v = mk(dev, 5'($urandom), 6'($urandom), 4'(cop), cop[0], 8'($urandom),
                   8'($urandom), dev, 5'($urandom), 5'b11110, 3'($urandom));
            play(v);
        end
        attn = 1'b1;
        @(negedge clk);

        // R1 back to back, start lane set inside beats two to four
        for (int i = 0; i < 6; i++) begin
            logic [39:0] a, b;
            a = mk(dev, 5'($urandom), 6'($urandom), 4'($urandom), 1'($urandom), 8'($urandom),
                   8'($urandom), dev, 5'($urandom), 5'($urandom), 3'($urandom));
            b = mk(dev, 5'($urandom), 6'($urandom), 4'($urandom), 1'($urandom), 8'($urandom),
                   8'($urandom), dev, 5'($urandom), 5'($urandom), 3'($urandom));
            a[10] = 1'b1; a[20] = 1'b1; a[30] = 1'b1;
            b[10] = 1'b1; b[30] = 1'b1;
            play2(a, b);
        end

        // R5 device number sweep on a write
        for (int d = 0; d < 32; d++) begin
            v = mk(5'(d), 5'($urandom), 6'($urandom), 4'b0001, 1'b1, 8'($urandom),
                   8'($urandom), 5'd0, 5'd0, 5'd0, 3'd0);
            play(v);
        end

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule